// File: doc/BRIEF.md
# Sorted Neighbour Candidate Queue

This block holds the best k candidates of one nearest-neighbour search, kept in distance order in a bank of parallel registers. A candidate (distance and point pointer) may arrive every clock. When its distance is below the current farthest kept distance, it is placed at its sorted position in the same cycle and the farthest kept entry falls off the end. Every slot compares itself with the candidate at once, so no insertion takes more than one cycle.

A search begins with an initialise pulse. It fills every slot with an empty placeholder at a bound distance and latches the queue length k. A large bound gives a plain k-nearest search. A radius bound gives a radius search capped at k results. The farthest kept distance is always on a port, so a tree walker can prune half-spaces with it. At the end of a search a readout pulse streams the k entries from nearest to farthest, one per cycle, and marks the last one.

Top module: `nbr_rank_queue`

## Requirements
- R1: After reset every slot is an empty placeholder with distance all ones and pointer 0, and k equals DEPTH. An initialise pulse refills every slot with an empty placeholder whose distance is `bound_i` and whose pointer is 0, and the next cycle `top_dist_o` equals `bound_i`.
- R2: k is latched from `k_i` on the initialise pulse. A value of 0 is taken as 1, and any value above DEPTH is taken as DEPTH.
- R3: A candidate is accepted only when `ins_valid_i` is high and `ins_dist_i` is strictly less than `top_dist_o`. A rejected candidate leaves the contents and `top_dist_o` unchanged. An accepted candidate removes the entry that was k-th nearest.
- R4: An accepted candidate is fully placed at the clock edge that samples it. The next cycle, `top_dist_o` reflects it, and back-to-back candidates on consecutive cycles are all placed.
- R5: A candidate whose distance equals a kept entry is placed farther than that entry, so earlier arrivals stay nearer.
- R6: `top_dist_o` always shows the distance of the k-th nearest kept entry, and the kept distances never decrease from nearest to farthest.
- R7: A `rd_start_i` pulse streams the k entries nearest first, one per cycle, starting the cycle after the pulse. `rd_valid_o` is high for exactly k cycles, and `rd_last_o` is high together with the k-th entry only.
- R8: During readout `rd_empty_o` is 1 with pointer 0 for a placeholder and 0 for a real candidate, whose pointer is given back unchanged.
- R9: While a readout is running, candidates and further `rd_start_i` pulses are ignored. An initialise pulse takes priority over a candidate in the same cycle, and it ends a running readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Start a new search: load placeholders and latch k |
| bound_i | input | DIST_W | Placeholder distance (search radius) |
| k_i | input | $clog2(DEPTH+1) | Requested queue length |
| ins_valid_i | input | 1 | Candidate present this cycle |
| ins_dist_i | input | DIST_W | Candidate distance |
| ins_ptr_i | input | PTR_W | Candidate point pointer |
| top_dist_o | output | DIST_W | Distance of the k-th nearest kept entry |
| rd_start_i | input | 1 | Begin sorted readout |
| rd_valid_o | output | 1 | Readout entry valid |
| rd_last_o | output | 1 | Readout entry is the k-th |
| rd_dist_o | output | DIST_W | Readout distance |
| rd_ptr_o | output | PTR_W | Readout pointer |
| rd_empty_o | output | 1 | Readout entry is a placeholder |

## Verification
A slot that fails to shift, or takes the candidate at the wrong place, shows on `top_dist_o` in the very next cycle whenever it lies at position k-1. Otherwise it shows during the next readout as an out-of-order distance or as a wrong pointer or wrong empty flag. A wrong latched k shows as a wrong pruning distance at once, and as a readout that is too long or too short. Each candidate is therefore followed by a check of the farthest distance, and the full sorted contents are compared at every readout.

// File: rtl/nbr_rank_pkg.sv
package nbr_rank_pkg;

   typedef enum logic {
      RD_IDLE = 1'b0,
      RD_RUN  = 1'b1
   } rd_state_e;

   // Map a requested queue length onto the legal range 1..depth.
   function automatic int clamp_len(input int req, input int depth);
      if (req < 1)
         return 1;
      else if (req > depth)
         return depth;
      else
         return req;
   endfunction

endpackage

// File: rtl/nbr_rank_slot.sv
// One position of the sorted bank. It compares with the candidate and either
// holds, takes the candidate, or takes its nearer neighbour's entry.
module nbr_rank_slot #(
   parameter int DIST_W = 16,
   parameter int PTR_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_i,
   input  logic [DIST_W-1:0] bound_i,
   input  logic              upd_i,
   input  logic [DIST_W-1:0] cand_dist_i,
   input  logic [PTR_W-1:0]  cand_ptr_i,
   input  logic              prev_far_i,
   input  logic [DIST_W-1:0] prev_dist_i,
   input  logic [PTR_W-1:0]  prev_ptr_i,
   input  logic              prev_empty_i,
   output logic              far_o,
   output logic [DIST_W-1:0] dist_o,
   output logic [PTR_W-1:0]  ptr_o,
   output logic              empty_o
);

   // Strictly farther than the candidate: equal entries stay in front.
   assign far_o = (cand_dist_i < dist_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dist_o  <= '1;
         ptr_o   <= '0;
         empty_o <= 1'b1;
      end else if (init_i) begin
         dist_o  <= bound_i;
         ptr_o   <= '0;
         empty_o <= 1'b1;
      end else if (upd_i && far_o) begin
         if (prev_far_i) begin
            dist_o  <= prev_dist_i;
            ptr_o   <= prev_ptr_i;
            empty_o <= prev_empty_i;
         end else begin
            dist_o  <= cand_dist_i;
            ptr_o   <= cand_ptr_i;
            empty_o <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/nbr_rank_reader.sv
// Sequences the nearest-first readout over the first k slots.
module nbr_rank_reader
   import nbr_rank_pkg::*;
#(
   parameter int DEPTH = 32,
   localparam int KW = $clog2(DEPTH + 1),
   localparam int IW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          abort_i,
   input  logic [KW-1:0] len_i,
   output logic          busy_o,
   output logic          last_o,
   output logic [IW-1:0] idx_o
);

   rd_state_e state_q;
   logic [IW-1:0] final_idx;

   assign final_idx = IW'(len_i - 1'b1);
   assign busy_o    = (state_q == RD_RUN);
   assign last_o    = busy_o && (idx_o == final_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RD_IDLE;
         idx_o   <= '0;
      end else if (abort_i) begin
         state_q <= RD_IDLE;
         idx_o   <= '0;
      end else begin
         case (state_q)
            RD_IDLE: begin
               if (start_i) begin
                  state_q <= RD_RUN;
                  idx_o   <= '0;
               end
            end
            RD_RUN: begin
               if (idx_o == final_idx) begin
                  state_q <= RD_IDLE;
                  idx_o   <= '0;
               end else begin
                  idx_o <= idx_o + 1'b1;
               end
            end
            default: state_q <= RD_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/nbr_rank_queue.sv
module nbr_rank_queue
   import nbr_rank_pkg::*;
#(
   parameter int DEPTH  = 32,
   parameter int DIST_W = 16,
   parameter int PTR_W  = 10,
   localparam int KW = $clog2(DEPTH + 1),
   localparam int IW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_i,
   input  logic [DIST_W-1:0] bound_i,
   input  logic [KW-1:0]     k_i,
   input  logic              ins_valid_i,
   input  logic [DIST_W-1:0] ins_dist_i,
   input  logic [PTR_W-1:0]  ins_ptr_i,
   output logic [DIST_W-1:0] top_dist_o,
   input  logic              rd_start_i,
   output logic              rd_valid_o,
   output logic              rd_last_o,
   output logic [DIST_W-1:0] rd_dist_o,
   output logic [PTR_W-1:0]  rd_ptr_o,
   output logic              rd_empty_o
);

   if (DEPTH < 2 || DEPTH > 32) begin : g_bad_depth
      $error("nbr_rank_queue: DEPTH must lie in 2..32");
   end
   if (DIST_W < 2 || PTR_W < 1) begin : g_bad_width
      $error("nbr_rank_queue: DIST_W >= 2 and PTR_W >= 1 required");
   end

   logic [DIST_W-1:0] s_dist  [DEPTH];
   logic [PTR_W-1:0]  s_ptr   [DEPTH];
   logic              s_empty [DEPTH];
   logic              s_far   [DEPTH];
   logic [DEPTH*DIST_W-1:0] slot_dist_flat;

   logic [KW-1:0] len_q;
   logic [KW-1:0] len_req;
   logic [IW-1:0] top_idx;
   logic [IW-1:0] rd_idx;
   logic          reading;
   logic          accept;

   assign len_req = KW'(clamp_len(int'(k_i), DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         len_q <= KW'(DEPTH);
      else if (init_i)
         len_q <= len_req;
   end

   assign top_idx    = IW'(len_q - 1'b1);
   assign top_dist_o = s_dist[top_idx];
   assign accept     = ins_valid_i && !init_i && !reading && (ins_dist_i < top_dist_o);

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic              upd;
      logic              pfar;
      logic [DIST_W-1:0] pdist;
      logic [PTR_W-1:0]  pptr;
      logic              pempty;

      assign upd = accept && (KW'(i) < len_q);

      if (i == 0) begin : g_head
         assign pfar   = 1'b0;
         assign pdist  = ins_dist_i;
         assign pptr   = ins_ptr_i;
         assign pempty = 1'b0;
      end else begin : g_body
         assign pfar   = s_far[i-1];
         assign pdist  = s_dist[i-1];
         assign pptr   = s_ptr[i-1];
         assign pempty = s_empty[i-1];
      end

      nbr_rank_slot #(
         .DIST_W (DIST_W),
         .PTR_W  (PTR_W)
      ) i_slot (
         .clk          (clk),
         .rst_n        (rst_n),
         .init_i       (init_i),
         .bound_i      (bound_i),
         .upd_i        (upd),
         .cand_dist_i  (ins_dist_i),
         .cand_ptr_i   (ins_ptr_i),
         .prev_far_i   (pfar),
         .prev_dist_i  (pdist),
         .prev_ptr_i   (pptr),
         .prev_empty_i (pempty),
         .far_o        (s_far[i]),
         .dist_o       (s_dist[i]),
         .ptr_o        (s_ptr[i]),
         .empty_o      (s_empty[i])
      );

      assign slot_dist_flat[i*DIST_W +: DIST_W] = s_dist[i];
   end

   nbr_rank_reader #(
      .DEPTH (DEPTH)
   ) i_reader (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (rd_start_i && !init_i),
      .abort_i (init_i),
      .len_i   (len_q),
      .busy_o  (reading),
      .last_o  (rd_last_o),
      .idx_o   (rd_idx)
   );

   assign rd_valid_o = reading;
   assign rd_dist_o  = s_dist[rd_idx];
   assign rd_ptr_o   = s_ptr[rd_idx];
   assign rd_empty_o = s_empty[rd_idx];

endmodule

// File: rtl/nbr_rank_queue_chk.sv
module nbr_rank_queue_chk #(
   parameter int DEPTH  = 32,
   parameter int DIST_W = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    init_i,
   input logic [DIST_W-1:0]       bound_i,
   input logic                    ins_valid_i,
   input logic [DIST_W-1:0]       ins_dist_i,
   input logic [DIST_W-1:0]       top_dist_o,
   input logic                    rd_valid_o,
   input logic                    rd_last_o,
   input logic [DEPTH*DIST_W-1:0] slot_dist_flat
);

   // R1: placeholders at the bound after an initialise pulse
   assert_init_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      init_i |=> (top_dist_o == $past(bound_i)));

   // R3: a rejected or blocked candidate leaves the pruning distance alone
   assert_reject_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_i && !(ins_valid_i && !rd_valid_o && (ins_dist_i < top_dist_o)))
      |=> $stable(top_dist_o));

   // R4: an accepted candidate never raises the pruning distance
   assert_accept_shrink_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_i && ins_valid_i && !rd_valid_o && (ins_dist_i < top_dist_o))
      |=> (top_dist_o <= $past(top_dist_o)));

   // R7: the last marker comes only with valid data, and a stream runs on to it
   assert_last_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last_o |-> rd_valid_o);

   assert_stream_cont_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid_o && !rd_last_o && !init_i) |=> rd_valid_o);

   // R6: the bank is ordered nearest to farthest
   for (genvar i = 0; i < DEPTH - 1; i++) begin : g_order
      assert_sorted_R6: assert property (@(posedge clk) disable iff (!rst_n)
         slot_dist_flat[i*DIST_W +: DIST_W] <= slot_dist_flat[(i+1)*DIST_W +: DIST_W]);
   end

endmodule

bind nbr_rank_queue nbr_rank_queue_chk #(
   .DEPTH  (DEPTH),
   .DIST_W (DIST_W)
) i_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .init_i         (init_i),
   .bound_i        (bound_i),
   .ins_valid_i    (ins_valid_i),
   .ins_dist_i     (ins_dist_i),
   .top_dist_o     (top_dist_o),
   .rd_valid_o     (rd_valid_o),
   .rd_last_o      (rd_last_o),
   .slot_dist_flat (slot_dist_flat)
);

// File: tb/test_nbr_rank_queue.sv
`timescale 1ns/1ps
module test_nbr_rank_queue;

   localparam int DEPTH  = 32;
   localparam int DIST_W = 16;
   localparam int PTR_W  = 10;
   localparam int KW     = $clog2(DEPTH + 1);
   localparam int NV     = 20;

   // Candidate distances for the table walk; the pointer is index + 1.
   localparam logic [DIST_W-1:0] VEC_D [NV] = '{
      16'd500, 16'd300, 16'd700, 16'd300, 16'd1200,
      16'd999, 16'd1000, 16'd50, 16'd800, 16'd300,
      16'd20,  16'd600, 16'd650, 16'd10, 16'd400,
      16'd900, 16'd1001, 16'd300, 16'd5,  16'd250
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              init_i = 1'b0;
   logic [DIST_W-1:0] bound_i = '0;
   logic [KW-1:0]     k_i = '0;
   logic              ins_valid_i = 1'b0;
   logic [DIST_W-1:0] ins_dist_i = '0;
   logic [PTR_W-1:0]  ins_ptr_i = '0;
   logic [DIST_W-1:0] top_dist_o;
   logic              rd_start_i = 1'b0;
   logic              rd_valid_o;
   logic              rd_last_o;
   logic [DIST_W-1:0] rd_dist_o;
   logic [PTR_W-1:0]  rd_ptr_o;
   logic              rd_empty_o;

   int nvec = 0;
   int nfail = 0;

   // Reference contents built from the requirements.
   int md [DEPTH];
   int mp [DEPTH];
   int me [DEPTH];
   int mk;

   always #10 clk = ~clk;

   nbr_rank_queue #(
      .DEPTH  (DEPTH),
      .DIST_W (DIST_W),
      .PTR_W  (PTR_W)
   ) i_nbr_rank_queue (
      .clk         (clk),
      .rst_n       (rst_n),
      .init_i      (init_i),
      .bound_i     (bound_i),
      .k_i         (k_i),
      .ins_valid_i (ins_valid_i),
      .ins_dist_i  (ins_dist_i),
      .ins_ptr_i   (ins_ptr_i),
      .top_dist_o  (top_dist_o),
      .rd_start_i  (rd_start_i),
      .rd_valid_o  (rd_valid_o),
      .rd_last_o   (rd_last_o),
      .rd_dist_o   (rd_dist_o),
      .rd_ptr_o    (rd_ptr_o),
      .rd_empty_o  (rd_empty_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      nvec++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic m_init(input int bound, input int k);
      mk = (k < 1) ? 1 : ((k > DEPTH) ? DEPTH : k);
      for (int j = 0; j < DEPTH; j++) begin
         md[j] = bound;
         mp[j] = 0;
         me[j] = 1;
      end
   endtask

   task automatic m_ins(input int d, input int p);
      int pos;
      if (d < md[mk-1]) begin
         pos = mk - 1;
         for (int j = mk - 1; j >= 0; j--)
            if (d < md[j]) pos = j;
         for (int j = mk - 1; j > pos; j--) begin
            md[j] = md[j-1];
            mp[j] = mp[j-1];
            me[j] = me[j-1];
         end
         md[pos] = d;
         mp[pos] = p;
         me[pos] = 0;
      end
   endtask

   task automatic do_init(input int bound, input int k);
      init_i  = 1'b1;
      bound_i = DIST_W'(bound);
      k_i     = KW'(k);
      step();
      init_i  = 1'b0;
      m_init(bound, k);
      chk("R1 top after init", int'(top_dist_o), bound);
   endtask

   task automatic do_ins(input int d, input int p);
      ins_valid_i = 1'b1;
      ins_dist_i  = DIST_W'(d);
      ins_ptr_i   = PTR_W'(p);
      step();
      ins_valid_i = 1'b0;
      m_ins(d, p);
      chk("R3 R4 R6 top after candidate", int'(top_dist_o), md[mk-1]);
   endtask

   task automatic do_read(input string tag);
      rd_start_i = 1'b1;
      step();
      rd_start_i = 1'b0;
      for (int j = 0; j < mk; j++) begin
         chk({tag, " R7 valid"}, int'(rd_valid_o), 1);
         chk({tag, " R7 dist"},  int'(rd_dist_o), md[j]);
         chk({tag, " R8 ptr"},   int'(rd_ptr_o), mp[j]);
         chk({tag, " R8 empty"}, int'(rd_empty_o), me[j]);
         chk({tag, " R7 last"},  int'(rd_last_o), (j == mk - 1) ? 1 : 0);
         step();
      end
      chk({tag, " R7 stream ended"}, int'(rd_valid_o), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired (R7 stream never ended)");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state, a full-length stream of all-ones placeholders
      m_init(32'hFFFF, DEPTH);
      chk("R1 reset top", int'(top_dist_o), 32'hFFFF);
      chk("R1 reset no stream", int'(rd_valid_o), 0);
      do_read("R1 reset");

      // Table walk: k=8, radius bound 1000 (1000 and above rejected, R3)
      do_init(1000, 8);
      for (int v = 0; v < NV; v++) begin
         do_ins(int'(VEC_D[v]), v + 1);
         if (v == 9) do_read("R6 mid table");
      end
      do_read("R6 end of table");

      // R9: candidates and a second start during readout are ignored
      rd_start_i = 1'b1;
      step();
      rd_start_i  = 1'b1;
      ins_valid_i = 1'b1;
      ins_dist_i  = 16'd1;
      ins_ptr_i   = 10'd99;
      repeat (3) step();
      rd_start_i  = 1'b0;
      ins_valid_i = 1'b0;
      while (rd_valid_o) step();
      chk("R9 top after ignored candidate", int'(top_dist_o), md[mk-1]);
      do_read("R9 contents unchanged");

      // R5: equal distances keep arrival order
      do_init(500, 4);
      do_ins(100, 1);
      do_ins(100, 2);
      do_ins(100, 3);
      do_read("R5 ties");
      chk("R5 second slot pointer", mp[1], 2);

      // R4: back-to-back candidates on consecutive cycles
      do_init(2000, 5);
      ins_valid_i = 1'b1;
      for (int j = 0; j < 6; j++) begin
         ins_dist_i = DIST_W'(900 - 100 * j);
         ins_ptr_i  = PTR_W'(j + 10);
         @(posedge clk);
         @(negedge clk);
         m_ins(900 - 100 * j, j + 10);
      end
      ins_valid_i = 1'b0;
      chk("R4 burst top", int'(top_dist_o), md[mk-1]);
      do_read("R4 burst");

      // R2: k of 0 is taken as 1
      do_init(100, 0);
      do_ins(60, 7);
      do_ins(40, 8);
      do_ins(40, 9);
      chk("R2 k0 top", int'(top_dist_o), 40);
      do_read("R2 k0");

      // R2: k above DEPTH is taken as DEPTH
      do_init(3000, 40);
      do_ins(30, 1);
      do_read("R2 k40");

      // R9: initialise wins over a candidate in the same cycle
      do_init(700, 3);
      do_ins(200, 5);
      init_i      = 1'b1;
      bound_i     = 16'd800;
      k_i         = KW'(3);
      ins_valid_i = 1'b1;
      ins_dist_i  = 16'd50;
      ins_ptr_i   = 10'd6;
      step();
      init_i      = 1'b0;
      ins_valid_i = 1'b0;
      m_init(800, 3);
      chk("R9 init beats candidate top", int'(top_dist_o), 800);
      do_read("R9 init priority");

      // R9: initialise ends a running readout
      do_ins(300, 4);
      rd_start_i = 1'b1;
      step();
      rd_start_i = 1'b0;
      step();
      init_i  = 1'b1;
      bound_i = 16'd900;
      k_i     = KW'(6);
      step();
      init_i = 1'b0;
      m_init(900, 6);
      chk("R9 readout aborted", int'(rd_valid_o), 0);
      chk("R1 top after abort", int'(top_dist_o), 900);
      do_read("R9 after abort");

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule